// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block divides one integer by another over many clock cycles. It has two operand sizes. In the word form, a 32-bit dividend is divided by a 16-bit divisor. The 16-bit remainder and the 16-bit quotient come back packed into one 32-bit result. In the long form, a 64-bit dividend is divided by a 32-bit divisor. The quotient and the remainder are reported for two separate destination registers. Each size runs in either an unsigned or a two's-complement signed form.

The surrounding pipeline pulses `start` with the operands and the current N/Z/V flags. It then waits for `done`. With `done`, the block states which destination writes to perform and with what data, the new flag values, and whether a divide-by-zero trap must be taken. The block itself writes no register file and builds no exception frame. The core is a restoring shift-subtract divider that works on magnitudes. Signs are applied afterwards.

Top module: `divq_flags_unit`

## Requirements
- R1: A divisor of zero gives `done` together with `dz_trap` one cycle after the start edge. No write enable is raised. N, Z and V repeat the flag inputs sampled at start. In the word form only `divisor[15:0]` is tested for zero.
- R2: `flag_c` is 0 after every operation, including traps and overflows.
- R3: In the word form (`op_mode[1]`=0), `wr_q_data[31:16]` holds the remainder and `wr_q_data[15:0]` holds the quotient. Only `wr_q_en` is raised.
- R4: Unsigned overflow (`op_mode[0]`=0) occurs when the quotient does not fit 16 bits (word form) or 32 bits (long form). On overflow, V=1, Z=0, N keeps the sampled `cur_n`, and neither write enable is raised.
- R5: Signed overflow (`op_mode[0]`=1) occurs when the quotient lies outside the signed range of the destination width. The most negative value, such as -32768 in the word form, is not an overflow. The outcome on overflow is the same as in R4.
- R6: Without overflow, V=0, N is the top bit of the quotient at the destination width, and Z is set when that quotient is zero.
- R7: In the long form (`op_mode[1]`=1), the quotient goes out on `wr_q_data` with `wr_q_en` and the remainder on `wr_r_data` with `wr_r_en`. When `same_dst` is 1, only the quotient write is raised.
- R8: The long-form dividend is `{dvd_hi, dvd_lo}`, with `dvd_hi` as the upper 32 bits.
- R9: Signed division truncates toward zero, and the remainder carries the sign of the dividend.
- R10: `done` is high for exactly one cycle. It rises 33 cycles after the start edge in the word form and 65 cycles after it in the long form.
- R11: A `start` pulse while an operation is in flight is ignored. It changes neither the result nor the timing of that operation, and it produces no second `done`.
- R12: The word form ignores `dvd_hi` and `divisor[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| op_mode | input | 2 | Bit 1: long form; bit 0: signed |
| dvd_hi | input | 32 | Upper dividend word (remainder register, long form) |
| dvd_lo | input | 32 | Lower dividend word (quotient register) |
| divisor | input | 32 | Divisor; the word form uses bits 15:0 |
| same_dst | input | 1 | Quotient and remainder destinations are one register |
| cur_n | input | 1 | Current N flag |
| cur_z | input | 1 | Current Z flag |
| cur_v | input | 1 | Current V flag |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | Divide-by-zero trap request, with done |
| wr_q_en | output | 1 | Write quotient destination, with done |
| wr_q_data | output | 32 | Quotient, or packed remainder:quotient |
| wr_r_en | output | 1 | Write remainder destination, with done |
| wr_r_data | output | 32 | Remainder (long form) |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_v | output | 1 | New V flag |
| flag_c | output | 1 | New C flag |

## Verification
A step counter that stops early or late shows up directly as a `done` that arrives off the fixed 33- or 65-cycle mark. It also corrupts the quotient, since the wrong number of bits is shifted in. A wrong partial remainder in the core does not stay hidden: it reaches the ports in the same operation, as a wrong quotient or remainder, or as a false overflow, so each directed case exposes it at its own `done`. A sign or range error in the formatting stage appears only in the signed cases. Those cases therefore cover negative divisors, negative dividends and the edges of each destination range.

// File: rtl/divq_pkg.sv
// Shared types for the iterative divider.
// Assumes op_mode bit 1 selects the long form and bit 0 selects signed.
package divq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic is_long;
        logic is_signed;
    } div_mode_t;
endpackage

// File: rtl/divq_prep.sv
// Operand preparation: takes the signs and magnitudes of dividend and divisor
// and detects a zero divisor. The word-form dividend magnitude is placed in
// the upper half, so that DATA_W shift steps produce its quotient.
// Assumes DATA_W is even.
module divq_prep #(
    parameter int unsigned DATA_W = 32
) (
    input  divq_pkg::div_mode_t      mode,
    input  logic [DATA_W-1:0]        dvd_hi,
    input  logic [DATA_W-1:0]        dvd_lo,
    input  logic [DATA_W-1:0]        dvs,
    output logic [2*DATA_W-1:0]      dvd_mag,
    output logic [DATA_W-1:0]        dvs_mag,
    output logic                     q_neg,
    output logic                     r_neg,
    output logic                     dvs_zero
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned DBL_W  = 2 * DATA_W;

    logic [DBL_W-1:0]  full_dvd;
    logic [DBL_W-1:0]  full_neg;
    logic [DATA_W-1:0] lo_neg;
    logic [DATA_W-1:0] dvs_neg;
    logic [HALF_W-1:0] short_dvs;
    logic [HALF_W-1:0] short_neg;
    logic              dvd_sign;
    logic              dvs_sign;

    // Select the sign and magnitude of each operand for the chosen form.
    always_comb begin
        full_dvd  = {dvd_hi, dvd_lo};
        full_neg  = -full_dvd;
        lo_neg    = -dvd_lo;
        dvs_neg   = -dvs;
        short_dvs = dvs[HALF_W-1:0];
        short_neg = -short_dvs;
        if (mode.is_long) begin
            dvd_sign = mode.is_signed & dvd_hi[DATA_W-1];
            dvs_sign = mode.is_signed & dvs[DATA_W-1];
            dvd_mag  = dvd_sign ? full_neg : full_dvd;
            dvs_mag  = dvs_sign ? dvs_neg : dvs;
            dvs_zero = (dvs == '0);
        end else begin
            dvd_sign = mode.is_signed & dvd_lo[DATA_W-1];
            dvs_sign = mode.is_signed & short_dvs[HALF_W-1];
            dvd_mag  = {(dvd_sign ? lo_neg : dvd_lo), {DATA_W{1'b0}}};
            dvs_mag  = {{(DATA_W-HALF_W){1'b0}}, (dvs_sign ? short_neg : short_dvs)};
            dvs_zero = (short_dvs == '0);
        end
        q_neg = dvd_sign ^ dvs_sign;
        r_neg = dvd_sign;
    end
endmodule

// File: rtl/divq_core.sv
// Restoring shift-subtract divider core. Each step retires one quotient bit.
// Assumes dvs_in is nonzero whenever steps are issued after a load.
module divq_core #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [2*DATA_W-1:0]     dvd_in,
    input  logic [DATA_W-1:0]       dvs_in,
    output logic [2*DATA_W-1:0]     quo,
    output logic [DATA_W-1:0]       rem
);
    localparam int unsigned DBL_W = 2 * DATA_W;

    logic [DBL_W-1:0]  quo_q;
    logic [DATA_W-1:0] rem_q;
    logic [DATA_W-1:0] dvs_q;
    logic [DATA_W:0]   trial;
    logic [DATA_W:0]   diff;

    // Form the next partial remainder and test it against the divisor.
    always_comb begin
        trial = {rem_q, quo_q[DBL_W-1]};
        diff  = trial - {1'b0, dvs_q};
    end

    // Load operands, or shift one bit and subtract when it fits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            quo_q <= dvd_in;
            rem_q <= '0;
            dvs_q <= dvs_in;
        end else if (step) begin
            if (!diff[DATA_W]) begin
                rem_q <= diff[DATA_W-1:0];
                quo_q <= {quo_q[DBL_W-2:0], 1'b1};
            end else begin
                rem_q <= trial[DATA_W-1:0];
                quo_q <= {quo_q[DBL_W-2:0], 1'b0};
            end
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < dvs_q)); // R9
endmodule

// File: rtl/divq_fmt.sv
// Result formatting: applies signs, detects overflow at the destination
// width, packs the word-form result and derives N and Z.
// Assumes quo holds the unsigned quotient magnitude and rem the remainder magnitude.
module divq_fmt #(
    parameter int unsigned DATA_W = 32
) (
    input  divq_pkg::div_mode_t      mode,
    input  logic [2*DATA_W-1:0]      quo,
    input  logic [DATA_W-1:0]        rem,
    input  logic                     q_neg,
    input  logic                     r_neg,
    output logic                     ovf,
    output logic [DATA_W-1:0]        q_word,
    output logic [DATA_W-1:0]        r_word,
    output logic                     res_n,
    output logic                     res_z
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned DBL_W  = 2 * DATA_W;
    localparam logic [DBL_W-1:0] W_POS_MAX = {{(DBL_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [DBL_W-1:0] W_NEG_LIM = W_POS_MAX + 1'b1;
    localparam logic [DBL_W-1:0] L_POS_MAX = {{(DBL_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [DBL_W-1:0] L_NEG_LIM = L_POS_MAX + 1'b1;

    logic [DBL_W-1:0]  q_val;
    logic [DATA_W-1:0] r_val;

    // Restore signs on quotient and remainder.
    always_comb begin
        q_val = q_neg ? -quo : quo;
        r_val = r_neg ? -rem : rem;
    end

    // Range test against the destination width for the selected form.
    always_comb begin
        if (mode.is_long) begin
            if (mode.is_signed) ovf = q_neg ? (quo > L_NEG_LIM) : (quo > L_POS_MAX);
            else                ovf = |quo[DBL_W-1:DATA_W];
        end else begin
            if (mode.is_signed) ovf = q_neg ? (quo > W_NEG_LIM) : (quo > W_POS_MAX);
            else                ovf = |quo[DBL_W-1:HALF_W];
        end
    end

    // Pack the destination words and derive N and Z from the quotient.
    always_comb begin
        r_word = r_val;
        if (mode.is_long) begin
            q_word = q_val[DATA_W-1:0];
            res_n  = q_val[DATA_W-1];
            res_z  = (q_val[DATA_W-1:0] == '0);
        end else begin
            q_word = {r_val[HALF_W-1:0], q_val[HALF_W-1:0]};
            res_n  = q_val[HALF_W-1];
            res_z  = (q_val[HALF_W-1:0] == '0);
        end
    end
endmodule

// File: rtl/divq_flags_unit.sv
// Multi-cycle divider with flag generation. It accepts an operation when
// idle, runs DATA_W or 2*DATA_W shift steps, and reports the writes, flags
// and any divide-by-zero trap with a one-cycle done pulse.
// Assumes the caller keeps start low until done, but tolerates pulses in between.
module divq_flags_unit #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] dvd_hi,
    input  logic [DATA_W-1:0] dvd_lo,
    input  logic [DATA_W-1:0] divisor,
    input  logic              same_dst,
    input  logic              cur_n,
    input  logic              cur_z,
    input  logic              cur_v,
    output logic              done,
    output logic              dz_trap,
    output logic              wr_q_en,
    output logic [DATA_W-1:0] wr_q_data,
    output logic              wr_r_en,
    output logic [DATA_W-1:0] wr_r_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    import divq_pkg::*;

    localparam int unsigned DBL_W = 2 * DATA_W;
    localparam int unsigned CNT_W = $clog2(DBL_W) + 1;
    localparam logic [CNT_W-1:0] LAST_LONG = CNT_W'(DBL_W - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(DATA_W - 1);

    div_state_e        state_q;
    div_mode_t         mode_in;
    div_mode_t         mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_step;
    logic              q_neg_q, r_neg_q, zero_q, same_q;
    logic              cn_q, cz_q, cv_q;
    logic [DBL_W-1:0]  prep_dvd;
    logic [DATA_W-1:0] prep_dvs;
    logic              prep_qneg, prep_rneg, prep_zero;
    logic [DBL_W-1:0]  core_quo;
    logic [DATA_W-1:0] core_rem;
    logic              fmt_ovf, fmt_n, fmt_z;
    logic [DATA_W-1:0] fmt_q, fmt_r;
    logic              accept;

    assign mode_in   = div_mode_t'(op_mode);
    assign accept    = (state_q == ST_IDLE) && start;
    assign last_step = mode_q.is_long ? LAST_LONG : LAST_WORD;

    divq_prep #(.DATA_W(DATA_W)) u_prep (
        .mode     (mode_in),
        .dvd_hi   (dvd_hi),
        .dvd_lo   (dvd_lo),
        .dvs      (divisor),
        .dvd_mag  (prep_dvd),
        .dvs_mag  (prep_dvs),
        .q_neg    (prep_qneg),
        .r_neg    (prep_rneg),
        .dvs_zero (prep_zero)
    );

    divq_core #(.DATA_W(DATA_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (state_q == ST_RUN),
        .dvd_in (prep_dvd),
        .dvs_in (prep_dvs),
        .quo    (core_quo),
        .rem    (core_rem)
    );

    divq_fmt #(.DATA_W(DATA_W)) u_fmt (
        .mode   (mode_q),
        .quo    (core_quo),
        .rem    (core_rem),
        .q_neg  (q_neg_q),
        .r_neg  (r_neg_q),
        .ovf    (fmt_ovf),
        .q_word (fmt_q),
        .r_word (fmt_r),
        .res_n  (fmt_n),
        .res_z  (fmt_z)
    );

    // Sequence control: capture the operation, count steps, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= '0;
            q_neg_q <= 1'b0;
            r_neg_q <= 1'b0;
            zero_q  <= 1'b0;
            same_q  <= 1'b0;
            cn_q    <= 1'b0;
            cz_q    <= 1'b0;
            cv_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_in;
                        q_neg_q <= prep_qneg;
                        r_neg_q <= prep_rneg;
                        zero_q  <= prep_zero;
                        same_q  <= same_dst;
                        cn_q    <= cur_n;
                        cz_q    <= cur_z;
                        cv_q    <= cur_v;
                        cnt_q   <= '0;
                        state_q <= prep_zero ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == last_step) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers: report writes, flags and trap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            dz_trap   <= 1'b0;
            wr_q_en   <= 1'b0;
            wr_r_en   <= 1'b0;
            wr_q_data <= '0;
            wr_r_data <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            done    <= 1'b0;
            dz_trap <= 1'b0;
            wr_q_en <= 1'b0;
            wr_r_en <= 1'b0;
            if (state_q == ST_FIN) begin
                done   <= 1'b1;
                flag_c <= 1'b0;
                if (zero_q) begin
                    dz_trap <= 1'b1;
                    flag_n  <= cn_q;
                    flag_z  <= cz_q;
                    flag_v  <= cv_q;
                end else if (fmt_ovf) begin
                    flag_n <= cn_q;
                    flag_z <= 1'b0;
                    flag_v <= 1'b1;
                end else begin
                    wr_q_en   <= 1'b1;
                    wr_r_en   <= mode_q.is_long & ~same_q;
                    wr_q_data <= fmt_q;
                    wr_r_data <= fmt_r;
                    flag_n    <= fmt_n;
                    flag_z    <= fmt_z;
                    flag_v    <= 1'b0;
                end
            end
        end
    end

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap |-> (done && !wr_q_en && !wr_r_en)); // R1
    AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v && !dz_trap) |-> (!wr_q_en && !wr_r_en && !flag_z)); // R4
    AST_REM_WRITE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_r_en |-> wr_q_en); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_WRITES_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q_en || dz_trap) |-> done); // R11
endmodule

// File: tb/divq_flags_unit_bench.sv
// Directed bench: one task per scenario, each checking its own results
// against a model written from the requirements.
module divq_flags_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic        same_dst = 1'b0, cur_n = 1'b0, cur_z = 1'b0, cur_v = 1'b0;
    logic        done, dz_trap, wr_q_en, wr_r_en;
    logic [31:0] wr_q_data, wr_r_data;
    logic        flag_n, flag_z, flag_v, flag_c;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    divq_flags_unit u_divq_flags_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor), .same_dst(same_dst),
        .cur_n(cur_n), .cur_z(cur_z), .cur_v(cur_v),
        .done(done), .dz_trap(dz_trap), .wr_q_en(wr_q_en), .wr_q_data(wr_q_data),
        .wr_r_en(wr_r_en), .wr_r_data(wr_r_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference behaviour computed from the requirements.
    task automatic model(input logic [1:0] md, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] dv, input logic same, input logic cn,
                         input logic cz, input logic cv,
                         output logic trap, output logic wq, output logic wr,
                         output logic [31:0] qd, output logic [31:0] rd,
                         output logic n, output logic z, output logic v, output int lat);
        logic [63:0] uq, ur;
        longint      a, b, sq, sr;
        logic        ovf;
        logic        is_long = md[1];
        logic        is_sgn = md[0];
        trap = is_long ? (dv == 0) : (dv[15:0] == 0);
        qd = '0; rd = '0; wq = 1'b0; wr = 1'b0;
        if (trap) begin
            n = cn; z = cz; v = cv; lat = 1;
            return;
        end
        lat = is_long ? 65 : 33;
        if (!is_long && !is_sgn) begin
            uq = {32'b0, lo} / {48'b0, dv[15:0]};
            ur = {32'b0, lo} % {48'b0, dv[15:0]};
            ovf = uq > 64'hFFFF;
        end else if (!is_long) begin
            a = longint'($signed(lo)); b = longint'($signed(dv[15:0]));
            sq = a / b; sr = a % b;
            uq = sq; ur = sr;
            ovf = (sq > 32767) || (sq < -32768);
        end else if (!is_sgn) begin
            uq = {hi, lo} / {32'b0, dv};
            ur = {hi, lo} % {32'b0, dv};
            ovf = uq > 64'hFFFF_FFFF;
        end else begin
            a = $signed({hi, lo}); b = longint'($signed(dv));
            sq = a / b; sr = a % b;
            uq = sq; ur = sr;
            ovf = (sq > 64'sd2147483647) || (sq < -64'sd2147483648);
        end
        if (ovf) begin
            n = cn; z = 1'b0; v = 1'b1;
        end else begin
            v = 1'b0; wq = 1'b1;
            if (is_long) begin
                qd = uq[31:0]; rd = ur[31:0]; wr = !same;
                n = uq[31]; z = (uq[31:0] == 0);
            end else begin
                qd = {ur[15:0], uq[15:0]};
                n = uq[15]; z = (uq[15:0] == 0);
            end
        end
    endtask

    // Drive one operation, wait for done, and compare every output.
    task automatic run_op(input string req, input logic [1:0] md, input logic [31:0] hi,
                          input logic [31:0] lo, input logic [31:0] dv, input logic same,
                          input logic cn, input logic cz, input logic cv, input bit poke);
        logic e_trap, e_wq, e_wr, e_n, e_z, e_v;
        logic [31:0] e_qd, e_rd;
        int e_lat;
        int lat = 0;
        model(md, hi, lo, dv, same, cn, cz, cv, e_trap, e_wq, e_wr, e_qd, e_rd, e_n, e_z, e_v, e_lat);
        @(negedge clk);
        op_mode = md; dvd_hi = hi; dvd_lo = lo; divisor = dv; same_dst = same;
        cur_n = cn; cur_z = cz; cur_v = cv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do begin
            @(negedge clk);
            lat++;
            if (poke && lat == 10) begin
                start = 1'b1; dvd_lo = 32'h1234_5678; divisor = 32'd3; op_mode = 2'b00;
            end else if (poke && lat == 11) begin
                start = 1'b0;
            end
        end while (!done && lat < 200);
        chk(req, "latency", 64'(lat), 64'(e_lat));
        chk(req, "dz_trap", 64'(dz_trap), 64'(e_trap));
        chk(req, "wr_q_en", 64'(wr_q_en), 64'(e_wq));
        chk(req, "wr_r_en", 64'(wr_r_en), 64'(e_wr));
        if (e_wq) chk(req, "wr_q_data", 64'(wr_q_data), 64'(e_qd));
        if (e_wr) chk(req, "wr_r_data", 64'(wr_r_data), 64'(e_rd));
        chk(req, "flag_n", 64'(flag_n), 64'(e_n));
        chk(req, "flag_z", 64'(flag_z), 64'(e_z));
        chk(req, "flag_v", 64'(flag_v), 64'(e_v));
        chk("R2", "flag_c", 64'(flag_c), 64'd0);
        @(negedge clk);
        chk("R10", "done width", 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        chk("reset", "done", 64'(done), 0);
        chk("reset", "wr_q_en", 64'(wr_q_en), 0);
        chk("reset", "wr_r_en", 64'(wr_r_en), 0);
        chk("reset", "dz_trap", 64'(dz_trap), 0);
        chk("reset", "flags", 64'({flag_n, flag_z, flag_v, flag_c}), 0);
    endtask

    task automatic t_word_unsigned; // R3 R6
        run_op("R3", 2'b00, 32'h0, 32'd100000, 32'd7, 1'b0, 1'b1, 1'b1, 1'b1, 0);
        run_op("R6", 2'b00, 32'h0, 32'd0, 32'd9, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        run_op("R6", 2'b00, 32'h0, 32'd65535, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_word_signed; // R9 R5
        run_op("R9", 2'b01, 32'h0, 32'hFFFF_FF9C, 32'd7, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R9", 2'b01, 32'h0, 32'd100, 32'h0000_FFF9, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R9", 2'b01, 32'h0, 32'hFFFF_FF9C, 32'h0000_FFF9, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R5", 2'b01, 32'h0, 32'hFFFF_0000, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R5", 2'b01, 32'h0, 32'h0001_0000, 32'd2, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        run_op("R5", 2'b01, 32'h0, 32'h8000_0000, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_word_overflow; // R4
        run_op("R4", 2'b00, 32'h0, 32'h0020_0000, 32'd2, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        run_op("R4", 2'b00, 32'h0, 32'h0001_0000, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_long_unsigned; // R7 R8 R4
        run_op("R8", 2'b10, 32'h1, 32'h0, 32'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R7", 2'b10, 32'h0, 32'hDEAD_BEEF, 32'h0001_0001, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R4", 2'b10, 32'h2, 32'h0, 32'd2, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    endtask

    task automatic t_long_signed; // R9 R5
        run_op("R9", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FC18, 32'hFFFF_FFF9, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R9", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FC18, 32'd7, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R5", 2'b11, 32'h0, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_op("R5", 2'b11, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_same_dst; // R7
        run_op("R7", 2'b10, 32'h0, 32'd1000, 32'd7, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        run_op("R7", 2'b11, 32'h0, 32'd1000, 32'hFFFF_FFF9, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_div_zero; // R1 R12
        run_op("R1", 2'b00, 32'h0, 32'd55, 32'd0, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        run_op("R1", 2'b11, 32'h5, 32'd55, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
        run_op("R12", 2'b01, 32'h0, 32'd55, 32'h0001_0000, 1'b0, 1'b1, 1'b1, 1'b1, 0);
    endtask

    task automatic t_word_ignore_upper; // R12
        run_op("R12", 2'b00, 32'hDEAD_BEEF, 32'd1000, 32'hFFFF_0005, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_busy_ignore; // R11
        int extra = 0;
        run_op("R11", 2'b10, 32'h3, 32'h1357_9BDF, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R11", "extra done", 64'(extra), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_unsigned();
        t_word_signed();
        t_word_overflow();
        t_long_unsigned();
        t_long_signed();
        t_same_dst();
        t_div_zero();
        t_word_ignore_upper();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule